// File: doc/BRIEF.md
# Rotating Four-Way Train Crossbar with In-Order Reassembly

The block joins four source streams, numbered A=0 to D=3, to four sink streams, numbered W=0 to Z=3, through a 4x4 crossbar. Every source is linked to exactly one sink at any time. The crossbar changes its permutation once per train. A schedule of four steps rotates the links, so that after four trains each sink has received one train's worth of partial-image fragments from every source.

Each sink keeps one holding FIFO for each source. Fragments can arrive at a sink in any source order. The sink releases them strictly in the source order A, B, C, D and then starts again at A. A fragment is released only after its final beat has been stored. On the way out, every beat carries the index of its source and the train tag that came in with it.

The train-boundary strobe does not switch the crossbar at once. It raises a pending request. The switch is applied only when no source is partway through a fragment. Until then, sources that are idle are not allowed to start a new fragment.

Top module: `rxs_train_xbar`

## Requirements
- R1: After a synchronous active-high reset the schedule is at step 0, no sink presents a beat (`snk_valid` all 0), and every source is ready (`src_ready` all 1).
- R2: A source with index s is routed to the sink with index (s + offset) mod 4. The offset for schedule steps 0, 1, 2 and 3 is 2, 1, 3 and 0.
- R3: The schedule step advances by exactly one, wrapping from 3 to 0, and only after a `train_tick` pulse has been seen.
- R4: A pending step change is applied only once no source is between the first and last beat of a fragment. While the change is pending, an idle source has `src_ready` low and a source in mid-fragment keeps `src_ready` high. The change takes effect on the edge after the last such beat.
- R5: Each sink releases whole fragments in the source order A, B, C, D, cycling. It starts a fragment only after that fragment's last beat is stored, and emits nothing beyond what was written. A fragment must be no longer than the FIFO depth.
- R6: The beats of a fragment leave contiguously and in arrival order. `snk_last` is set on the final beat only.
- R7: Each sink beat carries on `snk_src` the source index (2 bits per sink) and on `snk_tag` the train tag that came with the fragment.
- R8: While `snk_valid` is high and `snk_ready` is low, the data, last flag, source and tag of that sink hold steady. A holding FIFO is never written when full, because the source's `src_ready` is low instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_tick | input | 1 | Train-boundary strobe, one cycle |
| src_valid | input | 4 | Beat valid, one bit per source |
| src_ready | output | 4 | Beat accepted when valid and ready are both high |
| src_data | input | 4*DW | Beat payload, source s at bits [s*DW +: DW] |
| src_last | input | 4 | Final beat of a fragment |
| src_tag | input | 4*TW | Train number of the fragment |
| snk_valid | output | 4 | Beat valid, one bit per sink |
| snk_ready | input | 4 | Sink accepts beat |
| snk_data | output | 4*DW | Beat payload per sink |
| snk_last | output | 4 | Final beat of a fragment |
| snk_tag | output | 4*TW | Train tag of the fragment |
| snk_src | output | 8 | Source index of the beat, 2 bits per sink |

## Verification
The bench builds the block with DW=8, TW=4 and DEPTH=8. At that size the whole schedule can be covered: eight trains run, each schedule step is visited twice, and so every source-to-sink pairing occurs twice. Fragment lengths run from 1 to 4 beats with staggered gaps between beats. This scrambles the order in which fragments arrive, and it lets two fragments share one holding FIFO while the sink is still draining the previous round. A sink backpressure pattern exercises the hold requirement. In one train the strobe arrives while source A is mid-fragment, which brings the deferred switch and the blocking of idle sources within reach.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int NP = 4;
  localparam int PW = 2;
  typedef logic [PW-1:0] idx_t;

  // routing offset applied in each schedule step
  function automatic idx_t step_offset(idx_t step);
    case (step)
      2'd0:    return 2'd2;
      2'd1:    return 2'd1;
      2'd2:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // sink index for a source under a given offset (mod 4 by width)
  function automatic idx_t sink_of(idx_t src, idx_t off);
    return src + off;
  endfunction
endpackage

// File: rtl/rxs_sched.sv
module rxs_sched
  import rxs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          train_tick,
  input  logic [NP-1:0] acc,
  input  logic [NP-1:0] acc_last,
  output idx_t          step,
  output idx_t          offset,
  output logic [NP-1:0] block_start
);
  logic          pending;
  logic [NP-1:0] mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= '0;
      pending <= 1'b0;
      mid     <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (acc[i]) mid[i] <= !acc_last[i];
      end
      if (pending && (mid == '0)) begin
        step    <= step + 1'b1;
        pending <= train_tick;
      end else if (train_tick) begin
        pending <= 1'b1;
      end
    end
  end

  assign offset      = step_offset(step);
  assign block_start = pending ? ~mid : '0;

  // R3: the step only moves by one
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step)) |-> (step == $past(step) + 2'd1));
  // R3: the step only moves after a strobe was registered
  a_r3_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step)) |-> $past(pending));
  // R4: no source was mid-fragment when the switch happened
  a_r4_switch_idle: assert property (@(posedge clk) disable iff (rst)
    (step != $past(step)) |-> ($past(mid) == '0));
  // R4: a blocked source never begins a fragment
  a_r4_no_start: assert property (@(posedge clk) disable iff (rst)
    ((block_start & acc) == '0));
endmodule

// File: rtl/rxs_frag_fifo.sv
module rxs_frag_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         wr_last,
  input  logic         rd_en,
  output logic [W-1:0] rd_word,
  output logic         rd_last,
  output logic         full,
  output logic         has_frag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, fcnt;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= {wr_last, wr_word};
  end

  assign {rd_last, rd_word} = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      fcnt <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      cnt  <= cnt + CW'(wr_en) - CW'(rd_en);
      fcnt <= fcnt + CW'(wr_en && wr_last) - CW'(rd_en && rd_last);
    end
  end

  assign full     = (cnt == CW'(DEPTH));
  assign has_frag = (fcnt != '0);

  // R8: writes only land in free space
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  // R5: reads only take stored beats
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (cnt != '0));
endmodule

// File: rtl/rxs_sink_merge.sv
module rxs_sink_merge
  import rxs_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NP-1:0]   wr_en,
  input  logic [NP*W-1:0] wr_words,
  input  logic [NP-1:0]   wr_last,
  output logic [NP-1:0]   full,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [W-1:0]    out_word,
  output logic            out_last,
  output idx_t            out_src
);
  logic [W-1:0]  head_word [NP];
  logic [NP-1:0] head_last;
  logic [NP-1:0] has_frag;
  logic [NP-1:0] rd_en;
  idx_t          sel;
  logic          load;

  for (genvar s = 0; s < NP; s++) begin : g_src
    rxs_frag_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en[s]),
      .wr_word  (wr_words[s*W +: W]),
      .wr_last  (wr_last[s]),
      .rd_en    (rd_en[s]),
      .rd_word  (head_word[s]),
      .rd_last  (head_last[s]),
      .full     (full[s]),
      .has_frag (has_frag[s])
    );
    assign rd_en[s] = load && (sel == idx_t'(s));
  end

  assign load = (!out_valid || out_ready) && has_frag[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
      out_src   <= '0;
      sel       <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= head_word[sel];
      out_last  <= head_last[sel];
      out_src   <= sel;
      if (head_last[sel]) sel <= sel + 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled beat holds steady
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)
                                   && $stable(out_last) && $stable(out_src)));
  // R6: a fragment is not interrupted by another source
  a_r6_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_src == $past(out_src)));
endmodule

// File: rtl/rxs_train_xbar.sv
module rxs_train_xbar
  import rxs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int TW    = 4,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            train_tick,
  input  logic [3:0]      src_valid,
  output logic [3:0]      src_ready,
  input  logic [4*DW-1:0] src_data,
  input  logic [3:0]      src_last,
  input  logic [4*TW-1:0] src_tag,
  output logic [3:0]      snk_valid,
  input  logic [3:0]      snk_ready,
  output logic [4*DW-1:0] snk_data,
  output logic [3:0]      snk_last,
  output logic [4*TW-1:0] snk_tag,
  output logic [7:0]      snk_src
);
  localparam int W = DW + TW;

  idx_t            step, offset;
  logic [NP-1:0]   block_start;
  logic [NP-1:0]   acc;
  logic [NP*W-1:0] words;
  logic [NP-1:0]   full_m [NP];
  logic [NP-1:0]   wr_m   [NP];
  logic [W-1:0]    oword  [NP];

  assign acc = src_valid & src_ready;

  rxs_sched sched_i (
    .clk         (clk),
    .rst         (rst),
    .train_tick  (train_tick),
    .acc         (acc),
    .acc_last    (src_last),
    .step        (step),
    .offset      (offset),
    .block_start (block_start)
  );

  always_comb begin
    for (int s = 0; s < NP; s++) begin
      src_ready[s] = !block_start[s]
                     && !full_m[sink_of(idx_t'(s), offset)][s];
    end
  end

  for (genvar s = 0; s < NP; s++) begin : g_word
    assign words[s*W +: W] = {src_tag[s*TW +: TW], src_data[s*DW +: DW]};
  end

  for (genvar o = 0; o < NP; o++) begin : g_sink
    for (genvar s = 0; s < NP; s++) begin : g_route
      assign wr_m[o][s] = acc[s] && (sink_of(idx_t'(s), offset) == idx_t'(o));
    end

    rxs_sink_merge #(.W(W), .DEPTH(DEPTH)) merge_i (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_m[o]),
      .wr_words  (words),
      .wr_last   (src_last),
      .full      (full_m[o]),
      .out_ready (snk_ready[o]),
      .out_valid (snk_valid[o]),
      .out_word  (oword[o]),
      .out_last  (snk_last[o]),
      .out_src   (snk_src[o*2 +: 2])
    );

    assign snk_data[o*DW +: DW] = oword[o][DW-1:0];
    assign snk_tag[o*TW +: TW]  = oword[o][DW +: TW];
  end

  // R2: each accepted beat lands in exactly one sink FIFO
  for (genvar s = 0; s < NP; s++) begin : g_chk
    a_r2_one_sink: assert property (@(posedge clk) disable iff (rst)
      acc[s] |-> $onehot({wr_m[3][s], wr_m[2][s], wr_m[1][s], wr_m[0][s]}));
  end
  // R1: schedule starts at step 0 after reset
  a_r1_reset_step: assert property (@(posedge clk)
    $fell(rst) |-> (step == '0));
endmodule

// File: tb/rxs_train_xbar_tb_top.sv
`timescale 1ns/100ps
module rxs_train_xbar_tb_top;
  localparam int DW = 8, TW = 4, DEPTH = 8, NROUND = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic train_tick = 1'b0;
  logic [3:0] src_valid = '0, src_last = '0;
  logic [3:0] src_ready;
  logic [4*DW-1:0] src_data = '0;
  logic [4*TW-1:0] src_tag = '0;
  logic [3:0] snk_valid, snk_last;
  logic [3:0] snk_ready = '0;
  logic [4*DW-1:0] snk_data;
  logic [4*TW-1:0] snk_tag;
  logic [7:0] snk_src;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit bp_mode = 1'b1;
  bit a_first = 1'b0;
  int er [4], es [4], ek [4];
  bit prev_hold [4];
  logic [DW+TW+2:0] prev_snap [4];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rxs_train_xbar #(.DW(DW), .TW(TW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .train_tick(train_tick),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .src_last(src_last), .src_tag(src_tag),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .snk_last(snk_last), .snk_tag(snk_tag), .snk_src(snk_src));

  function automatic int off_of(int tp);
    case (tp) 0: return 2; 1: return 1; 2: return 3; default: return 0; endcase
  endfunction
  function automatic int frag_len(int s, int t);
    return 1 + ((3 * s + t) % 4);
  endfunction
  function automatic logic [7:0] enc(int t, int s, int k);
    return 8'(((t & 7) << 5) | ((s & 3) << 3) | (k & 7));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(int s, int t, bit slow);
    int len = frag_len(s, t);
    for (int k = 0; k < len; k++) begin
      bit r;
      repeat ((s + k) % 3 + ((slow && k > 0) ? 4 : 0)) @(negedge clk);
      src_valid[s] = 1'b1;
      src_data[s*DW +: DW] = enc(t, s, k);
      src_tag[s*TW +: TW] = TW'(t);
      src_last[s] = (k == len - 1);
      do begin
        #1 r = src_ready[s];
        @(negedge clk);
      end while (!r);
      src_valid[s] = 1'b0;
      if (slow && k == 0) a_first = 1'b1;
    end
  endtask

  task automatic pulse_tick();
    train_tick = 1'b1;
    @(negedge clk);
    train_tick = 1'b0;
  endtask

  // sink side: ready pattern and beat checks
  initial begin
    for (int o = 0; o < 4; o++) begin
      er[o] = 0; es[o] = 0; ek[o] = 0; prev_hold[o] = 0; prev_snap[o] = '0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      for (int o = 0; o < 4; o++)
        snk_ready[o] = bp_mode ? (((cyc + o) % 3) != 0) : 1'b1;
      #1;
      for (int o = 0; o < 4; o++) begin
        logic [DW+TW+2:0] snap;
        snap = {snk_last[o], snk_src[o*2 +: 2], snk_tag[o*TW +: TW], snk_data[o*DW +: DW]};
        if (!rst && prev_hold[o])
          check(snk_valid[o] && snap == prev_snap[o], "R8 stalled beat changed",
                int'(snap), int'(prev_snap[o]));
        if (!rst && snk_valid[o] && snk_ready[o]) begin
          int tp = 0, t, len;
          bit ok;
          for (int q = 0; q < 4; q++)
            if (((es[o] + off_of(q)) % 4) == o) tp = q;
          t = 4 * er[o] + tp;
          len = frag_len(es[o], t);
          ok = (er[o] < NROUND)
               && snk_data[o*DW +: DW] == enc(t, es[o], ek[o])
               && snk_last[o] == (ek[o] == len - 1)
               && int'(snk_src[o*2 +: 2]) == es[o]
               && int'(snk_tag[o*TW +: TW]) == t;
          // R2 R5 R6 R7: routing, source order, beat order and tagging
          check(ok, $sformatf("R2 R5 R6 R7 sink %0d beat", o), int'(snap),
                int'({(ek[o] == len - 1), 2'(es[o]), 4'(t), enc(t, es[o], ek[o])}));
          if (ek[o] == len - 1) begin
            ek[o] = 0;
            es[o] = (es[o] + 1) % 4;
            if (es[o] == 0) er[o]++;
          end else ek[o]++;
        end
        prev_hold[o] = snk_valid[o] && !snk_ready[o];
        prev_snap[o] = snap;
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(snk_valid == 4'h0, "R1 sinks idle after reset", snk_valid, 0);
    check(src_ready == 4'hF, "R1 sources ready after reset", src_ready, 4'hF);
    for (int t = 0; t < 4 * NROUND; t++) begin
      if (t == 4) bp_mode = 1'b0;
      if (t == 5) begin
        fork
          drive(1, t, 0); drive(2, t, 0); drive(3, t, 0);
        join
        fork
          drive(0, t, 1);
          begin
            wait (a_first);
            pulse_tick();
            #1;
            check(src_ready[3:1] == 3'b000, "R4 idle sources blocked while pending",
                  src_ready[3:1], 0);
            check(src_ready[0] == 1'b1, "R4 mid-fragment source keeps ready",
                  src_ready[0], 1);
          end
        join
        repeat (3) @(negedge clk);
        #1;
        check(src_ready == 4'hF, "R4 sources released after switch", src_ready, 4'hF);
      end else begin
        fork
          drive(0, t, 0); drive(1, t, 0); drive(2, t, 0); drive(3, t, 0);
        join
        pulse_tick();
        repeat (3) @(negedge clk);
      end
    end
    fork
      begin
        wait (er[0] == NROUND && er[1] == NROUND && er[2] == NROUND && er[3] == NROUND);
      end
    join
    repeat (10) @(negedge clk);
    #1;
    check(snk_valid == 4'h0, "R5 nothing beyond written fragments", snk_valid, 0);
    for (int o = 0; o < 4; o++)
      check(er[o] == NROUND && es[o] == 0 && ek[o] == 0,
            $sformatf("R5 sink %0d received all fragments", o), er[o], NROUND);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule